// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block derives a serial audio bit clock and two frame-sync signals, one for the transmit path and one for the receive path, from a single master clock. In master mode it divides the master clock down to the bit clock and counts bit periods to build each frame sync with a 50% duty cycle. In slave mode it takes the bit clock and both frame syncs from pins, passes them through a synchronizer and presents them on the same outputs. The serial shifters downstream see the same signals and strobes in both modes.

Every output is a plain level or a one-cycle strobe in the master clock domain. No data flows through the block, so it has no valid/ready handshake. Shifters use the rise and fall strobes instead of sampling the bit clock themselves. The divider inputs and the share selection can be changed at any time. A divider value is held in a working copy and takes effect only at a frame boundary, so no frame is ever cut short. The mode and polarity inputs act directly.

Top module: `aud_clkgen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `bclk`, `bclk_rise`, `bclk_fall`, `tx_fs` and `rx_fs` are all 0 when `bclk_invert` is 0.
- R2: In master mode the bit clock period is N master cycles, where N = `bit_div` + 1 and a `bit_div` of 0 is treated as 1. Each period begins with ceil(N/2) cycles low and ends with floor(N/2) cycles high, before inversion.
- R3: `bclk_rise` and `bclk_fall` each pulse for one cycle, in exactly the cycle where `bclk` first shows its new level. They are never both high.
- R4: In master mode a transmit frame lasts F bit periods, with F = `tx_frame_div` + 1 and a value of 0 treated as 1. The receive frame uses `rx_frame_div` in the same way and counts on its own. A value of 63 gives a 64-bit frame.
- R5: A master-mode frame sync is low for the first ceil(F/2) bits of each frame and high for the rest. It changes only on a launch edge. The launch edge is the `bclk` falling edge when `bclk_invert` is 0 and the rising edge when it is 1. A frame starts at the falling edge of its frame sync.
- R6: With `bclk_invert` = 1 the `bclk` output is the complement of the non-inverted clock, and the frame syncs then move with `bclk_rise`.
- R7: A new `tx_frame_div` or `bit_div` value takes effect from the next transmit frame start. When `frame_share` is 2, `bit_div` instead follows the receive frame start. A new `rx_frame_div` value takes effect from the next receive frame start. The frame in progress keeps its old length.
- R8: With `slave_mode` = 1, `bclk_oe` is 0. `bclk` equals `ext_bclk` XOR `bclk_invert`, delayed by 3 master cycles. `tx_fs` and `rx_fs` equal `ext_tx_fs` and `ext_rx_fs` with the same 3-cycle delay.
- R9: With `slave_mode` = 0, `bclk_oe` is 1.
- R10: `frame_share` selects the frame-sync routing. A value of 0 or 3 keeps the transmit and receive syncs independent. A value of 1 drives both outputs from the transmit sync. A value of 2 drives both from the receive sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_div | input | DIV_W | Master cycles per bit period, minus one |
| tx_frame_div | input | DIV_W | Bit periods per transmit frame, minus one |
| rx_frame_div | input | DIV_W | Bit periods per receive frame, minus one |
| slave_mode | input | 1 | 1: clocks come from pins; 0: block generates them |
| bclk_invert | input | 1 | Inverts the bit clock sense |
| frame_share | input | 2 | Frame-sync routing select |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_tx_fs | input | 1 | External transmit frame sync (slave mode) |
| ext_rx_fs | input | 1 | External receive frame sync (slave mode) |
| bclk | output | 1 | Bit clock |
| bclk_oe | output | 1 | Bit clock pin drive enable |
| bclk_rise | output | 1 | One-cycle strobe on a rising edge of bclk |
| bclk_fall | output | 1 | One-cycle strobe on a falling edge of bclk |
| tx_fs | output | 1 | Transmit frame sync |
| rx_fs | output | 1 | Receive frame sync |

## Verification
The bench changes dividers in the middle of a frame. A design that reloads at once would close that frame early, and its bit count and cycle count would both come out wrong. The clamp of zero dividers, odd ratios and the 64-bit frame are each measured at the launch edge. A wrong rounding of the half period or the half frame would show as an off-by-one in the high or low count. Inverted polarity, each share setting and the delay through the slave path are also covered. A design that moved the frame sync on the wrong edge, crossed the routing or dropped a synchronizer stage would show a missing launch strobe at the boundary, a frame length that belongs to the other path, or a 2-cycle delay.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

  typedef enum logic [1:0] {
    SHARE_OFF     = 2'd0,
    SHARE_TX      = 2'd1,
    SHARE_RX      = 2'd2,
    SHARE_OFF_ALT = 2'd3
  } share_e;

endpackage

// File: rtl/acg_bitdiv.sv
module acg_bitdiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         reload,
  input  logic [W-1:0] div_in,
  output logic         raw_next,
  output logic         launch
);

  logic [W-1:0] n_act;
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nx;
  logic [W-1:0] div_eff;
  logic [W:0]   low_len;

  assign div_eff = (div_in == '0) ? W'(1) : div_in;
  assign launch  = !init && (cnt == n_act);
  assign cnt_nx  = (init || launch) ? '0 : cnt + 1'b1;
  assign low_len = ({1'b0, n_act} + (W+1)'(2)) >> 1;
  assign raw_next = ({1'b0, cnt_nx} >= low_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      n_act <= W'(1);
    end else begin
      cnt <= cnt_nx;
      if (init || (launch && reload))
        n_act <= div_eff;
    end
  end

  AST_BDIV_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_act) |-> (cnt == '0)) else $error("bit divider reloaded mid-period"); // R7

  AST_BDIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (n_act != '0) && (cnt <= n_act)) else $error("bit counter out of range"); // R2

endmodule

// File: rtl/acg_framediv.sv
module acg_framediv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         launch,
  input  logic [W-1:0] div_in,
  output logic         fs_q,
  output logic         wrap
);

  logic [W-1:0] f_act;
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nx;
  logic [W-1:0] div_eff;
  logic [W:0]   low_bits;

  assign div_eff  = (div_in == '0) ? W'(1) : div_in;
  assign wrap     = launch && (cnt == f_act);
  assign low_bits = ({1'b0, f_act} + (W+1)'(2)) >> 1;

  always_comb begin
    if (init || wrap)  cnt_nx = '0;
    else if (launch)   cnt_nx = cnt + 1'b1;
    else               cnt_nx = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      f_act <= W'(1);
      fs_q  <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (init || wrap)
        f_act <= div_eff;
      if (init)
        fs_q <= 1'b0;
      else if (launch)
        fs_q <= ({1'b0, cnt_nx} >= low_bits);
    end
  end

  AST_FS_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_q) |-> $past(launch)) else $error("frame sync moved off a launch edge"); // R5

  AST_FDIV_RELOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(f_act) |-> (cnt == '0)) else $error("frame divider reloaded mid-frame"); // R7

endmodule

// File: rtl/acg_sync.sv
module acg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++)
        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clkgen_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] bit_div,
  input  logic [DIV_W-1:0] tx_frame_div,
  input  logic [DIV_W-1:0] rx_frame_div,
  input  logic             slave_mode,
  input  logic             bclk_invert,
  input  logic [1:0]       frame_share,
  input  logic             ext_bclk,
  input  logic             ext_tx_fs,
  input  logic             ext_rx_fs,
  output logic             bclk,
  output logic             bclk_oe,
  output logic             bclk_rise,
  output logic             bclk_fall,
  output logic             tx_fs,
  output logic             rx_fs
);

  localparam int N_PATH = 2;
  localparam int SYNC_W = 1 + N_PATH;

  logic                start_q;
  logic                m_raw_nx;
  logic                m_launch;
  logic                bdiv_reload;
  logic [N_PATH-1:0]   wrap;
  logic [N_PATH-1:0]   fs_m;
  logic [DIV_W-1:0]    fdiv_sel [N_PATH];
  logic [SYNC_W-1:0]   sync_q;
  logic [N_PATH-1:0]   sfs_q;
  logic                src;
  logic                out_nx;
  logic                pin_q;
  logic                rise_q;
  logic                fall_q;
  logic                tx_src;
  logic                rx_src;
  share_e              share;

  assign share       = share_e'(frame_share);
  assign fdiv_sel[0] = tx_frame_div;
  assign fdiv_sel[1] = rx_frame_div;
  assign bdiv_reload = (share == SHARE_RX) ? wrap[1] : wrap[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b1;
    else        start_q <= 1'b0;
  end

  acg_bitdiv #(.W(DIV_W)) u_bitdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (start_q),
    .reload   (bdiv_reload),
    .div_in   (bit_div),
    .raw_next (m_raw_nx),
    .launch   (m_launch)
  );

  for (genvar g = 0; g < N_PATH; g++) begin : g_frame
    acg_framediv #(.W(DIV_W)) u_framediv (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (start_q),
      .launch (m_launch),
      .div_in (fdiv_sel[g]),
      .fs_q   (fs_m[g]),
      .wrap   (wrap[g])
    );
  end

  acg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_rx_fs, ext_tx_fs, ext_bclk}),
    .q     (sync_q)
  );

  assign src    = slave_mode ? sync_q[0] : m_raw_nx;
  assign out_nx = src ^ bclk_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      sfs_q  <= '0;
    end else begin
      pin_q  <= out_nx;
      rise_q <= out_nx & ~pin_q;
      fall_q <= ~out_nx & pin_q;
      sfs_q  <= sync_q[SYNC_W-1:1];
    end
  end

  assign tx_src = slave_mode ? sfs_q[0] : fs_m[0];
  assign rx_src = slave_mode ? sfs_q[1] : fs_m[1];

  always_comb begin
    case (share)
      SHARE_TX: begin tx_fs = tx_src; rx_fs = tx_src; end
      SHARE_RX: begin tx_fs = rx_src; rx_fs = rx_src; end
      default:  begin tx_fs = tx_src; rx_fs = rx_src; end
    endcase
  end

  assign bclk      = pin_q;
  assign bclk_rise = rise_q;
  assign bclk_fall = fall_q;
  assign bclk_oe   = ~slave_mode;

  AST_RISE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |-> (bclk && !$past(bclk))) else $error("rise strobe misaligned"); // R3

  AST_FALL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |-> (!bclk && $past(bclk))) else $error("fall strobe misaligned"); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk_rise && bclk_fall)) else $error("both strobes high"); // R3

  AST_EDGE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk != $past(bclk)) |-> (bclk_rise || bclk_fall)) else $error("edge without strobe"); // R3

endmodule

// File: tb/test_aud_clkgen.sv
module test_aud_clkgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bit_div = 8'd3;
  logic [7:0] tx_frame_div = 8'd7;
  logic [7:0] rx_frame_div = 8'd4;
  logic       slave_mode = 1'b0;
  logic       bclk_invert = 1'b0;
  logic [1:0] frame_share = 2'd0;
  logic       ext_bclk = 1'b0;
  logic       ext_tx_fs = 1'b0;
  logic       ext_rx_fs = 1'b0;
  logic       bclk, bclk_oe, bclk_rise, bclk_fall, tx_fs, rx_fs;

  int n_chk = 0;
  int n_err = 0;

  typedef struct { string req; int val; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  aud_clkgen i_aud_clkgen (
    .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .tx_frame_div(tx_frame_div),
    .rx_frame_div(rx_frame_div), .slave_mode(slave_mode), .bclk_invert(bclk_invert),
    .frame_share(frame_share), .ext_bclk(ext_bclk), .ext_tx_fs(ext_tx_fs),
    .ext_rx_fs(ext_rx_fs), .bclk(bclk), .bclk_oe(bclk_oe), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .tx_fs(tx_fs), .rx_fs(rx_fs)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input string req, input int v);
    exp_t e;
    e.req = req;
    e.val = v;
    sb_q.push_back(e);
  endtask

  task automatic sb_cmp(input int act);
    exp_t e;
    if (sb_q.size() == 0) begin
      chk("R4 scoreboard underflow", act, -1);
    end else begin
      e = sb_q.pop_front();
      chk(e.req, act, e.val);
    end
  endtask

  // expected frame: launch strobe at start, bits, low bits, cycles
  task automatic push_frame(input string tag, input int f, input int n);
    push_exp({tag, " R5 launch at frame start"}, 1);
    push_exp({tag, " R4 bits per frame"}, f);
    push_exp({tag, " R5 low bits"}, (f + 1) / 2);
    push_exp({tag, " R4 cycles per frame"}, f * n);
  endtask

  function automatic logic fs_now(input bit rx);
    return rx ? rx_fs : tx_fs;
  endfunction

  function automatic logic launch_now();
    return bclk_invert ? bclk_rise : bclk_fall;
  endfunction

  task automatic wait_fall(input bit rx);
    logic p, c;
    c = fs_now(rx);
    do begin
      p = c;
      @(negedge clk);
      c = fs_now(rx);
    end while (!(p && !c));
  endtask

  task automatic measure_frame(input bit rx);
    int bits = 0, low = 0, cyc = 0;
    logic p;
    wait_fall(rx);
    sb_cmp(int'(launch_now()));
    do begin
      if (launch_now()) begin
        bits++;
        if (!fs_now(rx)) low++;
      end
      cyc++;
      p = fs_now(rx);
      @(negedge clk);
    end while (!(p && !fs_now(rx)));
    sb_cmp(bits);
    sb_cmp(low);
    sb_cmp(cyc);
  endtask

  task automatic measure_bclk(input int n);
    int cyc = 0, hi = 0;
    push_exp("R2 bit period", n);
    push_exp("R2 high cycles", n / 2);
    do @(negedge clk); while (!launch_now());
    do begin
      @(negedge clk);
      cyc++;
      if (bclk ^ bclk_invert) hi++;
    end while (!launch_now());
    sb_cmp(cyc);
    sb_cmp(hi);
  endtask

  // monitor: strobes must match the observed edges of bclk
  logic prev_bclk = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 rise strobe", int'(bclk_rise), int'(bclk && !prev_bclk));
      chk("R3 fall strobe", int'(bclk_fall), int'(!bclk && prev_bclk));
    end
    prev_bclk = bclk;
  end

  initial begin
    #(8 * 100000);
    chk("R4 watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int mism;
    logic d1, d2, d3, t1, t2, t3, r1, r2, r3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bclk in reset", int'(bclk), 0);
    chk("R1 rise in reset", int'(bclk_rise), 0);
    chk("R1 fall in reset", int'(bclk_fall), 0);
    chk("R1 tx_fs in reset", int'(tx_fs), 0);
    chk("R1 rx_fs in reset", int'(rx_fs), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bclk after reset", int'(bclk), 0);
    chk("R1 tx_fs after reset", int'(tx_fs), 0);
    chk("R9 master drives bclk", int'(bclk_oe), 1);

    // R2 R4 R5 base configuration
    push_frame("tx base", 8, 4);
    measure_frame(0);
    measure_bclk(4);
    push_frame("rx base", 5, 4);
    measure_frame(1);

    // odd ratio
    bit_div = 8'd2; tx_frame_div = 8'd4;
    push_frame("tx odd", 5, 3);
    measure_frame(0);
    measure_bclk(3);

    // zero clamps to one
    bit_div = 8'd0; tx_frame_div = 8'd0;
    push_frame("tx clamp", 2, 2);
    measure_frame(0);
    measure_bclk(2);

    // 64-bit frame
    bit_div = 8'd1; tx_frame_div = 8'd63;
    push_frame("tx 64 bit", 64, 2);
    measure_frame(0);

    // R7 change mid-frame
    bit_div = 8'd3; tx_frame_div = 8'd7;
    push_frame("tx settle", 8, 4);
    measure_frame(0);
    push_frame("R7 tx frame in progress", 8, 4);
    fork
      measure_frame(0);
      begin
        wait_fall(0);
        repeat (6) @(negedge clk);
        tx_frame_div = 8'd11;
        bit_div = 8'd1;
      end
    join
    push_frame("R7 tx next frame", 12, 2);
    measure_frame(0);
    push_frame("R7 rx frame in progress", 5, 2);
    fork
      measure_frame(1);
      begin
        wait_fall(1);
        repeat (3) @(negedge clk);
        rx_frame_div = 8'd6;
      end
    join
    push_frame("R7 rx next frame", 7, 2);
    measure_frame(1);

    // R6 inverted polarity
    bclk_invert = 1'b1; bit_div = 8'd3; tx_frame_div = 8'd7;
    push_frame("R6 inverted", 8, 4);
    measure_frame(0);
    measure_bclk(4);
    bclk_invert = 1'b0;

    // R10 share modes
    frame_share = 2'd1;
    wait_fall(1);
    push_frame("R10 rx follows tx", 8, 4);
    measure_frame(1);
    mism = 0;
    repeat (100) begin
      @(negedge clk);
      if (rx_fs != tx_fs) mism++;
    end
    chk("R10 share 1 rx equals tx", mism, 0);
    frame_share = 2'd2;
    wait_fall(0);
    push_frame("R10 tx follows rx", 7, 4);
    measure_frame(0);
    frame_share = 2'd3;
    wait_fall(0);
    push_frame("R10 share 3 tx", 8, 4);
    measure_frame(0);
    push_frame("R10 share 3 rx", 7, 4);
    measure_frame(1);
    frame_share = 2'd0;

    // R8 slave mode
    @(negedge clk);
    slave_mode = 1'b1;
    ext_bclk = 1'b0; ext_tx_fs = 1'b0; ext_rx_fs = 1'b0;
    d1 = 0; d2 = 0; d3 = 0; t1 = 0; t2 = 0; t3 = 0; r1 = 0; r2 = 0; r3 = 0;
    repeat (5) @(negedge clk);
    chk("R8 slave releases bclk", int'(bclk_oe), 0);
    mism = 0;
    for (int j = 0; j < 90; j++) begin
      @(negedge clk);
      if (bclk != (d3 ^ bclk_invert)) mism++;
      if (tx_fs != t3) mism++;
      if (rx_fs != r3) mism++;
      if (j == 50) bclk_invert = 1'b1;
      ext_bclk  = ((j % 6) < 3);
      ext_tx_fs = ((j % 24) >= 12);
      ext_rx_fs = ((j % 18) >= 9);
      d3 = d2; d2 = d1; d1 = ext_bclk;
      t3 = t2; t2 = t1; t1 = ext_tx_fs;
      r3 = r2; r2 = r1; r1 = ext_rx_fs;
    end
    chk("R8 slave path delay and inversion", mism, 0);
    slave_mode = 1'b0;
    bclk_invert = 1'b0;
    @(negedge clk);
    chk("R9 master drives bclk again", int'(bclk_oe), 1);
    chk("R4 scoreboard drained", sb_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule